// File: doc/BRIEF.md
# Serial Clock Source Divider Selector

This block generates the bit-rate clock enable for one serial channel. A source field picks one of three inputs: single-cycle pulses derived from either of two external clock pins, or the system clock itself, which counts on every cycle. A divisor then sets how many source events make one output period. Divisors of 1, 2 and 4 on an external pin go through a small direct prescaler. Larger divisors, and every divisor on the system clock, go through a down-counting baud rate generator that reloads each time it reaches zero.

Each source has its own set of legal divisors. The block checks the requested pair on every cycle and raises an error flag for a pair that is not legal. It never emits a tick from an illegal setting. A second counter applies the channel clock mode (x1, x16, x32 or x64) to the rate tick to make a bit-sample tick. Each time the generator reaches zero, a sticky status bit is set. That bit can drive an interrupt line.

Source, divisor and path change only at the end of the current output period, so no short period is ever produced. The clock mode changes only at the end of a bit period. Pin edge detection and the serial shift logic are outside this block.

Top module: `serclk_divsel`

## Requirements
- R1: `cfg_src` 0 selects `pin_a_pulse`, 1 selects `pin_b_pulse`, 2 selects the system clock (one event per cycle), and 3 is illegal; pulses on the pin that is not selected have no effect on the tick rate.
- R2: With source 0 the divisor is legal when it is 1 or a nonzero even value; 0 and odd values above 1 are illegal.
- R3: With source 1 only the divisors 1, 2 and 4 are legal.
- R4: With source 2 the divisor is legal when it is even and at least 4, up to the largest even value the field holds.
- R5: `cfg_err` is high exactly one cycle after an illegal source and divisor pair is presented. Once the period in progress ends with an illegal pair requested, `rate_tick` stays low.
- R6: With a legal active setting, `rate_tick` is a one-cycle pulse once every `cfg_div` events of the selected source.
- R7: `cfg_mode` 0, 1, 2 and 3 make `bit_tick` pulse once every 1, 16, 32 and 64 rate ticks, and it is only ever high together with `rate_tick`.
- R8: The generator path is used for source 0 with a divisor above 4 and for source 2. `zero_stat` is set each time the generator reaches zero and is cleared by `zero_clr`. The direct prescale path never sets it.
- R9: `irq` is high when `zero_stat` is high and `zero_irq_en` is high, and low otherwise.
- R10: A new source or divisor takes effect only at the end of the output period in progress, so the period during which the change arrives keeps its old length.
- R11: During reset `rate_tick`, `bit_tick`, `cfg_err`, `zero_stat` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; also the third clock source |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_a_pulse | input | 1 | One-cycle event per edge of the first external clock pin |
| pin_b_pulse | input | 1 | One-cycle event per edge of the second external clock pin |
| cfg_src | input | 2 | Clock source select: 0 pin A, 1 pin B, 2 system clock |
| cfg_div | input | DIV_W | Requested divisor |
| cfg_mode | input | 2 | Clock mode: 0 x1, 1 x16, 2 x32, 3 x64 |
| zero_irq_en | input | 1 | Enables the generator zero interrupt |
| zero_clr | input | 1 | Clears the sticky zero status |
| rate_tick | output | 1 | One-cycle bit-rate clock enable |
| bit_tick | output | 1 | One-cycle bit-sample tick after the mode multiplier |
| cfg_err | output | 1 | Requested source and divisor pair is illegal |
| zero_stat | output | 1 | Sticky flag: the generator reached zero |
| irq | output | 1 | Zero interrupt request |

## Verification
The bench sweeps every source code against every divisor from 0 to 12. It checks the error flag, the exact spacing between ticks and the zero status in each case. A design with a wrong legality rule shows up there either as ticks from a forbidden pair or as silence from an allowed one. A design that routes a divisor to the wrong path shows up as a zero status that is set or missing. Each source runs with the other pin pulsing at a different rate, so a source mux that listens to the wrong pin gives the wrong spacing. Further cases change the divisor in the middle of a period, which a design that loads at once would cut short. They also move to an illegal pair mid-run, where exactly one final tick is allowed. The remaining cases are the largest even system-clock divisor and all four clock-mode multipliers.

// File: rtl/serclk_pkg.sv
// Shared encodings for the serial clock divider selector.
// Assumes a two-bit source field whose code 3 is reserved.
package serclk_pkg;

    typedef enum logic [1:0] {
        SRC_PIN_A = 2'd0,
        SRC_PIN_B = 2'd1,
        SRC_SYS   = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    // Width of the clock mode counter, enough for the x64 multiplier.
    localparam int MODE_CNT_W = 6;

endpackage

// File: rtl/serclk_rule.sv
// Legality rule for a source and divisor pair, and choice of divide path.
// Purely combinational. Assumes DIV_W >= 3 so that the value 4 fits.
module serclk_rule
    import serclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic [1:0]       src,
    input  logic [DIV_W-1:0] div,
    output logic             legal,
    output logic             use_brg,
    output logic [1:0]       pre_lim
);
    localparam logic [DIV_W-1:0] DIV_ONE  = 1;
    localparam logic [DIV_W-1:0] DIV_TWO  = 2;
    localparam logic [DIV_W-1:0] DIV_FOUR = 4;

    logic is_one, is_two, is_four, is_even, is_zero, at_least4, above4;

    // Classify the divisor value.
    always_comb begin
        is_one    = (div == DIV_ONE);
        is_two    = (div == DIV_TWO);
        is_four   = (div == DIV_FOUR);
        is_zero   = (div == '0);
        is_even   = ~div[0];
        at_least4 = (div >= DIV_FOUR);
        above4    = (div > DIV_FOUR);
    end

    // Apply the per-source rule and pick the divide path.
    always_comb begin
        case (src_e'(src))
            SRC_PIN_A: begin
                legal   = is_one | (is_even & ~is_zero);
                use_brg = above4;
            end
            SRC_PIN_B: begin
                legal   = is_one | is_two | is_four;
                use_brg = 1'b0;
            end
            SRC_SYS: begin
                legal   = is_even & at_least4;
                use_brg = 1'b1;
            end
            default: begin
                legal   = 1'b0;
                use_brg = 1'b0;
            end
        endcase
    end

    // Terminal count of the direct prescaler: 0, 1 or 3.
    always_comb begin
        if (is_two)       pre_lim = 2'd1;
        else if (is_four) pre_lim = 2'd3;
        else              pre_lim = 2'd0;
    end

endmodule

// File: rtl/serclk_prescale.sv
// Direct prescaler for divide-by-1, 2 or 4. It counts enabled source
// events up to a terminal value latched on load.
// Assumes load and a terminal event never need to keep the old count.
module serclk_prescale (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       load,
    input  logic [1:0] lim_in,
    output logic       last
);
    logic [1:0] cnt_q;
    logic [1:0] lim_q;

    // Terminal event: an enabled source event at the last count.
    assign last = en && (cnt_q == lim_q);

    // Count events; restart at terminal or on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= 2'd0;
            lim_q <= 2'd0;
        end else if (load) begin
            cnt_q <= 2'd0;
            lim_q <= lim_in;
        end else if (en) begin
            cnt_q <= last ? 2'd0 : cnt_q + 2'd1;
        end
    end

    AST_PRE_LIM_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        lim_q != 2'd2); // R3

    AST_PRE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R6

endmodule

// File: rtl/serclk_brg.sv
// Down-counting baud rate generator. On load it takes divisor-1 as both
// the count and the reload value. It reports the zero event and reloads there.
// Assumes the loaded divisor is at least 1 (the caller loads only legal pairs).
module serclk_brg #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             load,
    input  logic [DIV_W-1:0] div_in,
    output logic             last
);
    localparam logic [DIV_W-1:0] DIV_ONE = 1;

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] lim_q;

    // Zero event: an enabled source event with the count at zero.
    assign last = en && (cnt_q == '0);

    // Count down; reload from the held value at zero or from the input on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (load) begin
            cnt_q <= div_in - DIV_ONE;
            lim_q <= div_in - DIV_ONE;
        end else if (en) begin
            cnt_q <= last ? lim_q : cnt_q - DIV_ONE;
        end
    end

    AST_BRG_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R6

endmodule

// File: rtl/serclk_mode_mult.sv
// Clock mode multiplier: counts rate ticks and marks every 1st, 16th,
// 32nd or 64th one as a bit-sample tick. A new mode is taken at a bit boundary.
// Assumes hold is high while the block has no legal active setting.
module serclk_mode_mult
    import serclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       hold,
    input  logic [1:0] mode_in,
    output logic       last
);
    logic [MODE_CNT_W-1:0] cnt_q;
    logic [MODE_CNT_W-1:0] lim_q;
    logic [MODE_CNT_W-1:0] lim_req;

    // Map the mode code to its terminal count.
    always_comb begin
        case (mode_in)
            2'd0:    lim_req = MODE_CNT_W'(0);
            2'd1:    lim_req = MODE_CNT_W'(15);
            2'd2:    lim_req = MODE_CNT_W'(31);
            default: lim_req = MODE_CNT_W'(63);
        endcase
    end

    // Bit boundary: a rate tick at the last count.
    assign last = en && !hold && (cnt_q == lim_q);

    // Count rate ticks; restart and take the mode at a boundary or while held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            lim_q <= '0;
        end else if (hold || last) begin
            cnt_q <= '0;
            lim_q <= lim_req;
        end else if (en) begin
            cnt_q <= cnt_q + MODE_CNT_W'(1);
        end
    end

    AST_MULT_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= lim_q); // R7

endmodule

// File: rtl/serclk_divsel.sv
// Serial clock source divider selector for one channel. Picks a source,
// checks the divisor against that source's rule, and divides through the
// direct prescaler or the baud rate generator. It then applies the clock
// mode multiplier. The active setting is captured only at a period end, or
// whenever nothing legal is active.
// Assumes the pin pulse inputs are single-cycle and already synchronous to clk.
module serclk_divsel
    import serclk_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pin_a_pulse,
    input  logic             pin_b_pulse,
    input  logic [1:0]       cfg_src,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic [1:0]       cfg_mode,
    input  logic             zero_irq_en,
    input  logic             zero_clr,
    output logic             rate_tick,
    output logic             bit_tick,
    output logic             cfg_err,
    output logic             zero_stat,
    output logic             irq
);
    logic       req_legal, req_brg;
    logic [1:0] req_pre_lim;

    logic       act_valid_q;
    src_e       act_src_q;
    logic       act_brg_q;

    logic       src_event;
    logic       pre_en, brg_en, pre_last, brg_last;
    logic       period_end, reload, load_pre, load_brg;
    logic       mult_last;

    logic       rate_q, bit_q, err_q, zero_q;

    serclk_rule #(.DIV_W(DIV_W)) u_rule (
        .src     (cfg_src),
        .div     (cfg_div),
        .legal   (req_legal),
        .use_brg (req_brg),
        .pre_lim (req_pre_lim)
    );

    // Route the selected source's events.
    always_comb begin
        case (act_src_q)
            SRC_PIN_A: src_event = pin_a_pulse;
            SRC_PIN_B: src_event = pin_b_pulse;
            SRC_SYS:   src_event = 1'b1;
            default:   src_event = 1'b0;
        endcase
    end

    // Steer events to the active path and decide when to reload.
    always_comb begin
        pre_en     = act_valid_q && !act_brg_q && src_event;
        brg_en     = act_valid_q &&  act_brg_q && src_event;
        period_end = act_brg_q ? brg_last : pre_last;
        reload     = period_end || !act_valid_q;
        load_pre   = reload && req_legal && !req_brg;
        load_brg   = reload && req_legal &&  req_brg;
    end

    serclk_prescale u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (pre_en),
        .load   (load_pre),
        .lim_in (req_pre_lim),
        .last   (pre_last)
    );

    serclk_brg #(.DIV_W(DIV_W)) u_brg (
        .clk    (clk),
        .rst_n  (rst_n),
        .en     (brg_en),
        .load   (load_brg),
        .div_in (cfg_div),
        .last   (brg_last)
    );

    serclk_mode_mult u_mult (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (period_end),
        .hold    (!act_valid_q),
        .mode_in (cfg_mode),
        .last    (mult_last)
    );

    // Capture the requested setting at a period end or while idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_valid_q <= 1'b0;
            act_src_q   <= SRC_NONE;
            act_brg_q   <= 1'b0;
        end else if (reload) begin
            act_valid_q <= req_legal;
            act_src_q   <= src_e'(cfg_src);
            act_brg_q   <= req_brg;
        end
    end

    // Register the tick outputs and the error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rate_q <= 1'b0;
            bit_q  <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            rate_q <= period_end;
            bit_q  <= mult_last;
            err_q  <= !req_legal;
        end
    end

    // Sticky zero status: set by a generator zero, else cleared on request.
    always_ff @(posedge clk) begin
        if (!rst_n)        zero_q <= 1'b0;
        else if (brg_last) zero_q <= 1'b1;
        else if (zero_clr) zero_q <= 1'b0;
    end

    assign rate_tick = rate_q;
    assign bit_tick  = bit_q;
    assign cfg_err   = err_q;
    assign zero_stat = zero_q;
    assign irq       = zero_q && zero_irq_en;

    AST_BIT_WITH_RATE: assert property (@(posedge clk) disable iff (!rst_n)
        bit_tick |-> rate_tick); // R7

    AST_ONE_PATH: assert property (@(posedge clk) disable iff (!rst_n)
        !(pre_last && brg_last)); // R6

    AST_ZERO_FROM_BRG: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_stat && !$past(zero_stat)) |-> $past(brg_last)); // R8

endmodule

// File: tb/test_serclk_divsel.sv
// Sweep bench for the serial clock divider selector.
module test_serclk_divsel;
    localparam int DIV_W = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             pin_a = 1'b0, pin_b = 1'b0;
    logic [1:0]       cfg_src = 2'd0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic [1:0]       cfg_mode = 2'd0;
    logic             irq_en = 1'b0, zclr = 1'b0;
    logic             rate_tick, bit_tick, cfg_err, zero_stat, irq;

    serclk_divsel #(.DIV_W(DIV_W)) i_serclk_divsel (
        .clk(clk), .rst_n(rst_n), .pin_a_pulse(pin_a), .pin_b_pulse(pin_b),
        .cfg_src(cfg_src), .cfg_div(cfg_div), .cfg_mode(cfg_mode),
        .zero_irq_en(irq_en), .zero_clr(zclr),
        .rate_tick(rate_tick), .bit_tick(bit_tick), .cfg_err(cfg_err),
        .zero_stat(zero_stat), .irq(irq)
    );

    int total = 0, bad = 0, cyc = 0;
    int gap_a = 2, gap_b = 3;
    int last_rate = -1, last_bit = -1, n_rate = 0, n_bit = 0;
    int rate_err = 0, bit_err = 0, rate_act = 0, bit_act = 0;
    int exp_rsp = 0, exp_bsp = 0;
    logic got_rate = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_track();
        n_rate = 0; n_bit = 0; rate_err = 0; bit_err = 0;
        last_rate = -1; last_bit = -1;
    endtask

    // One cycle: sample outputs at the falling edge, then drive pin events.
    task automatic step();
        @(negedge clk);
        cyc++;
        got_rate = rate_tick;
        if (rate_tick) begin
            if (n_rate > 0 && (cyc - last_rate) != exp_rsp) begin
                rate_err++; rate_act = cyc - last_rate;
            end
            last_rate = cyc; n_rate++;
        end
        if (bit_tick) begin
            if (n_bit > 0 && (cyc - last_bit) != exp_bsp) begin
                bit_err++; bit_act = cyc - last_bit;
            end
            last_bit = cyc; n_bit++;
        end
        pin_a = (gap_a > 0) && (cyc % gap_a == 0);
        pin_b = (gap_b > 0) && (cyc % gap_b == 0);
    endtask

    task automatic next_tick(output int g);
        int prev = last_rate;
        int lim = 0;
        step();
        while (!got_rate && lim < 2000) begin
            step(); lim++;
        end
        g = cyc - prev;
    endtask

    function automatic bit f_legal(input int s, input int d);
        if (s == 0) return (d == 1) || (d > 0 && d % 2 == 0);
        if (s == 1) return (d == 1) || (d == 2) || (d == 4);
        if (s == 2) return (d % 2 == 0) && (d >= 4);
        return 1'b0;
    endfunction

    function automatic bit f_brg(input int s, input int d);
        return (s == 0 && d > 4) || (s == 2);
    endfunction

    function automatic int f_mult(input int m);
        if (m == 0) return 1;
        if (m == 1) return 16;
        if (m == 2) return 32;
        return 64;
    endfunction

    task automatic sweep_case(input int s, input int d, input int m, input int n,
                              input bit chk_bit);
        string tag;
        bit lg;
        if (s == 0)      tag = "R2";
        else if (s == 1) tag = "R3";
        else if (s == 2) tag = "R4";
        else             tag = "R1";
        tag = $sformatf("%s src=%0d div=%0d mode=%0d", tag, s, d, m);
        cfg_src  = 2'(s);
        cfg_div  = DIV_W'(d);
        cfg_mode = 2'(m);
        rst_n = 1'b0;
        repeat (2) step();
        rst_n = 1'b1;
        if (s == 0)      exp_rsp = gap_a * d;
        else if (s == 1) exp_rsp = gap_b * d;
        else             exp_rsp = d;
        exp_bsp = exp_rsp * f_mult(m);
        clear_track();
        repeat (n) step();
        lg = f_legal(s, d);
        chk(cfg_err == !lg, {tag, " R5 error flag"}, int'(cfg_err), int'(!lg));
        if (lg)
            chk(n_rate >= 2 && rate_err == 0, {tag, " R6 R1 rate spacing"},
                (rate_err != 0) ? rate_act : n_rate, exp_rsp);
        else
            chk(n_rate == 0, {tag, " R5 no tick"}, n_rate, 0);
        chk(zero_stat == (lg && f_brg(s, d)), {tag, " R8 zero status"},
            int'(zero_stat), int'(lg && f_brg(s, d)));
        if (chk_bit)
            chk(n_bit >= 2 && bit_err == 0, {tag, " R7 bit spacing"},
                (bit_err != 0) ? bit_act : n_bit, exp_bsp);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int g0, g1, g2;
        // R11: reset state.
        cfg_src = 2'd2; cfg_div = DIV_W'(4); irq_en = 1'b1;
        repeat (3) step();
        chk(rate_tick == 1'b0, "R11 rate_tick in reset", int'(rate_tick), 0);
        chk(bit_tick == 1'b0, "R11 bit_tick in reset", int'(bit_tick), 0);
        chk(cfg_err == 1'b0, "R11 cfg_err in reset", int'(cfg_err), 0);
        chk(zero_stat == 1'b0, "R11 zero_stat in reset", int'(zero_stat), 0);
        chk(irq == 1'b0, "R11 irq in reset", int'(irq), 0);
        irq_en = 1'b0;

        // R1 R2 R3 R4 R6: every source against divisors 0..12.
        for (int s = 0; s < 4; s++)
            for (int d = 0; d <= 12; d++)
                sweep_case(s, d, 0, 200, 1'b0);

        // R7: all clock modes on the system clock, divide by 4.
        for (int m = 0; m < 4; m++)
            sweep_case(2, 4, m, 1100, 1'b1);

        // R4: largest legal even divisor and the odd maximum.
        sweep_case(2, 254, 0, 800, 1'b0);
        sweep_case(2, 255, 0, 100, 1'b0);

        // R10: divisor change in mid period keeps the old period length.
        sweep_case(2, 8, 0, 30, 1'b0);
        exp_rsp = 0;
        next_tick(g0);
        next_tick(g0);
        chk(g0 == 8, "R10 period before change", g0, 8);
        repeat (3) step();
        cfg_div = DIV_W'(4);
        next_tick(g1);
        chk(g1 == 8, "R10 period during change", g1, 8);
        next_tick(g2);
        chk(g2 == 4, "R10 period after change", g2, 4);

        // R5: change to an illegal pair mid run; one last tick, then none.
        repeat (2) step();
        cfg_div = DIV_W'(5);
        clear_track();
        step();
        chk(cfg_err == 1'b1, "R5 error one cycle after illegal", int'(cfg_err), 1);
        repeat (40) step();
        chk(n_rate == 1, "R5 ticks after illegal request", n_rate, 1);

        // R8 R9: clear on the direct path, then set again by the generator.
        gap_a = 0; gap_b = 0;
        cfg_src = 2'd1; cfg_div = DIV_W'(2);
        repeat (3) step();
        zclr = 1'b1;
        step();
        zclr = 1'b0;
        repeat (5) step();
        chk(zero_stat == 1'b0, "R8 zero_stat cleared", int'(zero_stat), 0);
        irq_en = 1'b1;
        step();
        chk(irq == 1'b0, "R9 irq with status low", int'(irq), 0);
        gap_b = 2; exp_rsp = 4;
        clear_track();
        repeat (50) step();
        chk(n_rate >= 2 && rate_err == 0, "R3 R6 direct path spacing",
            (rate_err != 0) ? rate_act : n_rate, 4);
        chk(zero_stat == 1'b0, "R8 direct path leaves status low", int'(zero_stat), 0);
        cfg_src = 2'd2; cfg_div = DIV_W'(4);
        repeat (30) step();
        chk(zero_stat == 1'b1, "R8 generator sets status", int'(zero_stat), 1);
        chk(irq == 1'b1, "R9 irq enabled", int'(irq), 1);
        irq_en = 1'b0;
        step();
        chk(irq == 1'b0, "R9 irq disabled", int'(irq), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule